// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block is the digital timing logic that sits beside a 12-bit successive-approximation converter. It picks one of four conversion-clock sources and divides it by an integer from 1 to 8. It picks one of four sample triggers, can invert it, and passes it through a two-flop synchroniser. It then opens a sample window. The window either follows the trigger or is held open by a timer for a programmed number of conversion clocks. When the window closes, the block runs a fixed 13-cycle conversion that builds a 12-bit result from an external comparator bit.

The whole block runs on one system clock. Each clock source is presented as a one-cycle tick in that domain, so a divided "conversion clock" is a tick count rather than a separate clock net. The `sampleHold` output is high while the analog front end should track and low while it should hold. `done` pulses for one cycle when a fresh result is on `result`.

Top module: `sar_seq_top`

## Requirements
- R1: While `rstN` is low and after its release, with no trigger, `sampleHold`, `busy` and `done` are 0 and `result` is 0.
- R2: Only ticks of the source indexed by `clkSel` advance the conversion clock. One conversion-clock cycle is `clkDiv`+1 selected ticks, with `clkDiv` from 0 to 7. The divider restarts at the start of each window and each conversion.
- R3: The effective trigger is `trigIn[trigSel]` XOR `trigInvert`. Its rising edge passes a two-flop synchroniser, and `sampleHold` goes high on the third rising clock edge after the edge is set up.
- R4: With `pulseMode`=0, `sampleHold` stays high until the synchronised trigger falls, so the window is exactly as many clocks as the trigger was high.
- R5: With `pulseMode`=1, the window lasts exactly 4·2^`sampTime` conversion clocks, whatever the trigger does after its rising edge.
- R6: Conversion starts in the first cycle with `sampleHold` low. It takes exactly 13 conversion clocks. With every source tick present, `done` goes high 13·(`clkDiv`+1) clocks after that first cycle, for exactly one cycle.
- R7: Conversion-clock k (k = 0..11) stores the `cmpIn` value into result bit 11−k, MSB first. The 13th cycle copies the 12 bits to `result`, and `result` holds them until the next `done`.
- R8: A window can start only when both `enable` and `powerOn` are 1. A trigger edge that arrives while either is 0 opens no window.
- R9: Clearing `enable` after a window has closed does not stop the conversion. `done` and the result still arrive on schedule.
- R10: A trigger rising edge that arrives while a conversion runs is ignored. After `done` no window opens until a new rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 4 | One-cycle tick per conversion-clock source (index 0 internal oscillator, 1..3 system clocks) |
| clkSel | input | 2 | Conversion-clock source select |
| clkDiv | input | 3 | Divider minus one (0 gives divide-by-1, 7 gives divide-by-8) |
| trigIn | input | 4 | Trigger inputs (index 0 software start, 1..3 timer outputs) |
| trigSel | input | 2 | Trigger select |
| trigInvert | input | 1 | Invert the selected trigger |
| pulseMode | input | 1 | 1: timer-sized window, 0: window follows trigger |
| sampTime | input | 2 | Timer window exponent N, window = 4·2^N conversion clocks |
| enable | input | 1 | Sequencer enable |
| powerOn | input | 1 | Converter power |
| cmpIn | input | 1 | Comparator decision bit |
| sampleHold | output | 1 | 1 = track (sample window open), 0 = hold |
| busy | output | 1 | Window or conversion in progress |
| result | output | 12 | Last completed conversion result |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The window opens three clocks after the bench drives the trigger edge at a falling clock edge. It closes three clocks after the trigger drops in direct mode, or after 4·2^N·D clocks in timer mode. `done` is due exactly 13·D clocks after the first cycle with `sampleHold` low. The bench counts falling clock edges from each stimulus and compares that count with the due cycle, rather than waiting for an event with slack. The comparator model changes `cmpIn` at falling edges from the same count, so that bit k is presented during the k-th D-clock block of the conversion. A wrong bit order or a wrong divider therefore shows up both in `result` and in the latency.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W  = 12;
  localparam int SRC_N  = 4;
  localparam int TRIG_N = 4;
  localparam int DIV_W  = 3;
  localparam int ST_W   = 2;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int TSEL_W = $clog2(TRIG_N);
  localparam int CNT_W  = $clog2(RES_W + 1);
  localparam int IDX_W  = $clog2(RES_W);
  localparam int TMR_W  = 2 + (1 << ST_W);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seqState_t;

  typedef struct packed {
    logic             divRestart;
    logic             bitTake;
    logic [IDX_W-1:0] bitIdx;
    logic             latch;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcTick,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              cmpIn,
  input  seqStrobe_t        strobe,
  output logic              convTick,
  output logic [RES_W-1:0]  result,
  output logic              done
);
  logic             srcSel;
  logic [DIV_W-1:0] divCnt;
  logic [RES_W-1:0] work;
  logic [CNT_W-1:0] bitsSeen;

  assign srcSel   = srcTick[clkSel];
  assign convTick = srcSel && (divCnt >= clkDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (strobe.divRestart) divCnt <= '0;
    else if (srcSel)           divCnt <= convTick ? '0 : divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      if (strobe.bitTake) work[strobe.bitIdx] <= cmpIn;
      if (strobe.latch) result <= work;
      done <= strobe.latch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitsSeen <= '0;
    else if (strobe.latch)   bitsSeen <= '0;
    else if (strobe.bitTake) bitsSeen <= bitsSeen + CNT_W'(1);
  end

  assert_latch_after_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |-> (bitsSeen == CNT_W'(RES_W)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [TSEL_W-1:0] trigSel,
  input  logic              trigInvert,
  input  logic              pulseMode,
  input  logic [ST_W-1:0]   sampTime,
  input  logic              enable,
  input  logic              powerOn,
  input  logic              convTick,
  output logic              window,
  output logic              busy,
  output seqStrobe_t        strobe
);
  seqState_t        state, stateNext;
  logic [2:0]       syncQ;
  logic             trigRaw, trigLvl, trigRise, gateOk;
  logic [TMR_W-1:0] tmr, tmrLast;
  logic [CNT_W-1:0] cnv;

  assign trigRaw  = trigIn[trigSel] ^ trigInvert;
  assign trigLvl  = syncQ[1];
  assign trigRise = syncQ[1] & ~syncQ[2];
  assign gateOk   = enable & powerOn;
  assign tmrLast  = (TMR_W'(4) << sampTime) - TMR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], trigRaw};
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (gateOk && trigRise) stateNext = ST_SAMPLE;
      ST_SAMPLE:  if (pulseMode ? (convTick && tmr == tmrLast) : !trigLvl)
                    stateNext = ST_CONVERT;
      ST_CONVERT: if (convTick && cnv == CNT_W'(RES_W)) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
      cnv <= '0;
    end else if (strobe.divRestart) begin
      tmr <= '0;
      cnv <= '0;
    end else if (convTick) begin
      if (state == ST_SAMPLE)  tmr <= tmr + TMR_W'(1);
      if (state == ST_CONVERT) cnv <= cnv + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.divRestart = (stateNext != state);
    strobe.bitTake    = (state == ST_CONVERT) && convTick && (cnv < CNT_W'(RES_W));
    strobe.bitIdx     = IDX_W'(RES_W - 1) - cnv[IDX_W-1:0];
    strobe.latch      = (state == ST_CONVERT) && convTick && (cnv == CNT_W'(RES_W));
  end

  assign window = (state == ST_SAMPLE);
  assign busy   = (state != ST_IDLE);

  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !gateOk) |=> (state == ST_IDLE));

  assert_conv_no_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONVERT) |=> (state != ST_SAMPLE));

  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAMPLE && pulseMode && $stable(sampTime)) |-> (tmr <= tmrLast));

  assert_window_enters_conv_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAMPLE && stateNext != ST_SAMPLE) |=> (state == ST_CONVERT));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcTick,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [TSEL_W-1:0] trigSel,
  input  logic              trigInvert,
  input  logic              pulseMode,
  input  logic [ST_W-1:0]   sampTime,
  input  logic              enable,
  input  logic              powerOn,
  input  logic              cmpIn,
  output logic              sampleHold,
  output logic              busy,
  output logic [RES_W-1:0]  result,
  output logic              done
);
  seqStrobe_t strobe;
  logic       convTick;

  sar_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .trigSel(trigSel),
    .trigInvert(trigInvert), .pulseMode(pulseMode), .sampTime(sampTime),
    .enable(enable), .powerOn(powerOn), .convTick(convTick),
    .window(sampleHold), .busy(busy), .strobe(strobe)
  );

  sar_seq_dpath uDpath (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .clkSel(clkSel),
    .clkDiv(clkDiv), .cmpIn(cmpIn), .strobe(strobe), .convTick(convTick),
    .result(result), .done(done)
  );
endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  localparam time CLK_PERIOD = 10;

  // vector: {divCode[2:0], sel[1:0], inv, win[3:0], code[11:0]}
  localparam logic [21:0] VEC [8] = '{
    {3'd0, 2'd0, 1'b0, 4'd3, 12'hA5C},
    {3'd1, 2'd1, 1'b1, 4'd4, 12'h3F0},
    {3'd2, 2'd2, 1'b0, 4'd5, 12'hFFF},
    {3'd3, 2'd3, 1'b1, 4'd6, 12'h000},
    {3'd4, 2'd0, 1'b1, 4'd3, 12'h801},
    {3'd5, 2'd1, 1'b0, 4'd7, 12'h555},
    {3'd6, 2'd2, 1'b1, 4'd4, 12'hAAA},
    {3'd7, 2'd3, 1'b0, 4'd9, 12'h123}
  };

  logic clk = 0, rstN = 0;
  logic [3:0] srcTick = 4'hF, trigIn = 4'h0;
  logic [1:0] clkSel = 0, trigSel = 0, sampTime = 0;
  logic [2:0] clkDiv = 0;
  logic trigInvert = 0, pulseMode = 0, enable = 0, powerOn = 1, cmpIn = 0;
  logic sampleHold, busy, done;
  logic [11:0] result;

  int errors = 0, checks = 0, cyc = 0;
  logic [1:0] curSel = 0;
  logic curInv = 0;

  sar_seq_top dut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .clkSel(clkSel), .clkDiv(clkDiv),
    .trigIn(trigIn), .trigSel(trigSel), .trigInvert(trigInvert),
    .pulseMode(pulseMode), .sampTime(sampTime), .enable(enable),
    .powerOn(powerOn), .cmpIn(cmpIn), .sampleHold(sampleHold), .busy(busy),
    .result(result), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic setTrig(input logic lvl);
    trigIn[curSel] = lvl ^ curInv;
  endtask

  task automatic setup(input logic [1:0] sel, input logic inv, input logic [2:0] dv,
                       input logic pm, input logic [1:0] st);
    enable = 0;
    curSel = sel; curInv = inv;
    trigSel = sel; trigInvert = inv; clkDiv = dv; pulseMode = pm; sampTime = st;
    trigIn = inv ? 4'hF : 4'h0;
    repeat (5) @(negedge clk);
    enable = 1;
    repeat (2) @(negedge clk);
  endtask

  // Call at the negedge where sampleHold is first seen low.
  task automatic convWait(input int d, input logic [11:0] code, input int raiseAt,
                          input bit dropEn, output int n);
    n = 0;
    cmpIn = code[11];
    if (dropEn) enable = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
      if (n == raiseAt) setTrig(1);
      cmpIn = (n / d < 12) ? code[11 - n / d] : 1'b0;
    end
  endtask

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    chk(sampleHold == 0 && busy == 0 && done == 0 && result == 0, "R1 in reset", {busy, done, sampleHold}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(sampleHold == 0 && busy == 0 && done == 0 && result == 0, "R1 after reset", {busy, done, sampleHold}, 0);

    // Table walk: divider 1..8, every trigger input, both polarities (R2 R3 R4 R6 R7)
    foreach (VEC[i]) begin
      int d, w;
      logic [11:0] code;
      d = int'(VEC[i][21:19]) + 1;
      w = int'(VEC[i][15:12]);
      code = VEC[i][11:0];
      setup(VEC[i][18:17], VEC[i][16], VEC[i][21:19], 0, 0);
      setTrig(1);
      hi = 0;
      for (int k = 1; k <= w; k++) begin
        @(negedge clk);
        if (k == 2) chk(sampleHold == 0, "R3 window before sync", sampleHold, 0);
        if (k == 3) chk(sampleHold == 1, "R3 window on third edge", sampleHold, 1);
        if (sampleHold) hi++;
        if (k == w) setTrig(0);
      end
      n = 0;
      while (n < 40) begin
        @(negedge clk);
        n++;
        if (sampleHold) hi++; else break;
      end
      chk(hi == w, "R4 direct window length", hi, w);
      convWait(d, code, -1, 0, n);
      chk(n == 13 * d, "R6 done latency 13*D", n, 13 * d);
      chk(result == code, "R7 MSB-first result", result, code);
      @(negedge clk);
      chk(done == 0, "R6 done one cycle", done, 0);
      chk(result == code, "R7 result held", result, code);
    end

    // R5: timer window for each sampTime, trigger dropped after one cycle
    for (int st = 0; st < 4; st++) begin
      setup(2'd1, 0, 3'd1, 1, 2'(st));
      setTrig(1);
      @(negedge clk);
      setTrig(0);
      hi = 0; n = 0;
      while (n < 200) begin
        @(negedge clk);
        n++;
        if (sampleHold) hi++; else if (hi > 0) break;
      end
      chk(hi == (4 << st) * 2, "R5 timer window length", hi, (4 << st) * 2);
      convWait(2, 12'h6C3, -1, 0, n);
      chk(n == 26 && result == 12'h6C3, "R5 conversion after timer window", result, 12'h6C3);
    end

    // R8: enable low blocks, then power low blocks
    for (int g = 0; g < 2; g++) begin
      setup(2'd2, 1, 3'd0, 0, 0);
      if (g == 0) enable = 0; else powerOn = 0;
      setTrig(1);
      hi = 0;
      repeat (12) begin
        @(negedge clk);
        if (sampleHold || busy) hi++;
      end
      chk(hi == 0, g == 0 ? "R8 enable low blocks" : "R8 power low blocks", hi, 0);
      setTrig(0);
      repeat (4) @(negedge clk);
      enable = 1; powerOn = 1;
      repeat (4) @(negedge clk);
      chk(sampleHold == 0 && busy == 0, "R8 no late window", {busy, sampleHold}, 0);
    end

    // R9: enable cleared right after window closes
    setup(2'd0, 0, 3'd2, 0, 0);
    setTrig(1);
    repeat (4) @(negedge clk);
    setTrig(0);
    while (sampleHold) @(negedge clk);
    convWait(3, 12'h9E7, -1, 1, n);
    chk(n == 39, "R9 conversion completes after enable clear", n, 39);
    chk(result == 12'h9E7, "R9 result after enable clear", result, 12'h9E7);
    enable = 1;

    // R10: trigger rise during conversion is ignored
    setup(2'd3, 0, 3'd1, 0, 0);
    setTrig(1);
    repeat (4) @(negedge clk);
    setTrig(0);
    while (sampleHold) @(negedge clk);
    convWait(2, 12'h0F1, 5, 0, n);
    chk(n == 26, "R10 latency with trigger during conversion", n, 26);
    hi = 0;
    repeat (20) begin
      @(negedge clk);
      if (sampleHold || busy) hi++;
    end
    chk(hi == 0, "R10 no window after done", hi, 0);
    setTrig(0);
    repeat (4) @(negedge clk);

    // R2: unselected sources do not advance the conversion clock
    setup(2'd0, 0, 3'd0, 0, 0);
    clkSel = 2'd2;
    srcTick = 4'b1011;
    setTrig(1);
    repeat (4) @(negedge clk);
    setTrig(0);
    while (sampleHold) @(negedge clk);
    hi = 0;
    repeat (40) begin
      @(negedge clk);
      if (done) hi++;
    end
    chk(hi == 0 && busy == 1, "R2 stalled without selected source", hi, 0);
    srcTick = 4'b1111;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 13, "R2 resumes on selected source", n, 13);
    clkSel = 0;

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule